// File: doc/BRIEF.md
# Three-Mode Power State Controller

This controller decides when a processor subsystem may stop its clocks and when it may cut power to its blocks. It keeps the subsystem in one of three operating modes: Run, where everything is live; Idle, where the clocks are gated; and Sleep, where the clocks are gated and the blocks are shut down. A policy layer asks for Idle or Sleep. An interrupt brings the subsystem out of Idle, and a wake-up event brings it out of Sleep.

Each move between modes has its own fixed cost. Entering Idle or leaving it is short. Entering Sleep is longer, and leaving Sleep is by far the longest. Each cost is given as a time in nanoseconds and is turned into a cycle count from the clock period, so a simulation can pass scaled-down times. While a move is in progress the busy flag is high and every input is ignored. The mode output always reports which gating set is in force, so a testbench can weight it by the power figure of that mode (roughly 400 mW in Run, 50 mW in Idle and 0.16 mW in Sleep) and accumulate energy.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode output is Run (code 0), both gating outputs are low and busy is low.
- R2: The mode code is 0 for Run, 1 for Idle and 2 for Sleep. Run has clock gate 0 and shutdown 0, Idle has clock gate 1 and shutdown 0, and Sleep has clock gate 1 and shutdown 1. Busy and either gating output are never high together.
- R3: In Run with busy low, a high idle request starts entry to Idle. Busy is high for exactly the Run-to-Idle cycle count. The mode code and the clock gate change to Idle on the edge on which busy falls.
- R4: In Run with busy low, a high sleep request starts entry to Sleep, and it wins over an idle request in the same cycle. Busy lasts the Run-to-Sleep count, and both gating outputs rise only when busy falls.
- R5: In Idle only the interrupt causes an exit, and the wake-up input is ignored. On the edge that accepts the interrupt, the mode becomes Run, both gates are released and busy rises for the Idle-to-Run count.
- R6: In Sleep only the wake-up input causes an exit, and the interrupt is ignored. On the edge that accepts the wake-up event, both gates are released and busy rises for the Sleep-to-Run count.
- R7: While busy is high, idle request, sleep request, interrupt and wake-up are all ignored. The mode and the gating outputs follow only the transition already under way.
- R8: Idle and Sleep never switch directly. A sleep request in Idle and an idle request in Sleep have no effect.
- R9: Each cycle count is the ceiling of the latency in nanoseconds times 1000, divided by the clock period in picoseconds, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idle_req_i | input | 1 | Policy request to enter Idle |
| sleep_req_i | input | 1 | Policy request to enter Sleep |
| irq_i | input | 1 | Interrupt, exit event for Idle |
| wake_i | input | 1 | Wake-up event, exit event for Sleep |
| clk_gate_en_o | output | 1 | Clock gating enable |
| blk_shdn_en_o | output | 1 | Block shutdown enable |
| mode_o | output | 2 | Mode in force: 0 Run, 1 Idle, 2 Sleep |
| busy_o | output | 1 | High while a mode transition is in progress |

## Verification
The hardest cases to reach are the ones where an input arrives during a transition: an exit event or a new request that shows up while the block is still entering a mode, or while it is on its way back to Run. The stimulus reaches these by pulsing the interrupt, the wake-up input and both requests in the middle of each busy window, and then walking through every cycle of the transition. It also drives the wrong exit event and the cross-mode request while the block rests in Idle and in Sleep. Short latency parameters with different lengths, one of which needs rounding up, keep the long Sleep exit within a few dozen cycles and still make the ceiling rule visible.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_SLEEP = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    ST_RUN        = 3'd0,
    ST_ENT_IDLE   = 3'd1,
    ST_IDLE       = 3'd2,
    ST_EXIT_IDLE  = 3'd3,
    ST_ENT_SLEEP  = 3'd4,
    ST_SLEEP      = 3'd5,
    ST_EXIT_SLEEP = 3'd6
  } pmc_state_e;

  // Latency in ns to cycles: ceil(ns*1000/period_ps), at least one cycle.
  function automatic int unsigned lat_cycles(input int unsigned lat_ns,
                                             input int unsigned period_ps);
    longint unsigned t_ps;
    longint unsigned cyc;
    t_ps = 64'(lat_ns) * 64'd1000;
    cyc  = (t_ps + 64'(period_ps) - 64'd1) / 64'(period_ps);
    if (cyc == 64'd0) cyc = 64'd1;
    return 32'(cyc);
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic logic is_transient(input pmc_state_e s);
    return (s == ST_ENT_IDLE) || (s == ST_EXIT_IDLE) ||
           (s == ST_ENT_SLEEP) || (s == ST_EXIT_SLEEP);
  endfunction

endpackage

// File: rtl/pmc_latency_timer.sv
module pmc_latency_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             active_o,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      cnt_q    <= load_val_i;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active_o  = active_q;
  assign expired_o = active_q && (cnt_q == '0);

  // R7
  load_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !active_q);

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q != '0 && !load_i) |=> (active_q && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned CYC_R2I   = 1,
  parameter int unsigned CYC_I2R   = 1,
  parameter int unsigned CYC_R2S   = 1,
  parameter int unsigned CYC_S2R   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req_i,
  input  logic             sleep_req_i,
  input  logic             irq_i,
  input  logic             wake_i,
  input  logic             expired_i,
  output pmc_state_e       state_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);
  localparam logic [CNT_W-1:0] LD_R2I = CNT_W'(CYC_R2I - 1);
  localparam logic [CNT_W-1:0] LD_I2R = CNT_W'(CYC_I2R - 1);
  localparam logic [CNT_W-1:0] LD_R2S = CNT_W'(CYC_R2S - 1);
  localparam logic [CNT_W-1:0] LD_S2R = CNT_W'(CYC_S2R - 1);

  pmc_state_e state_q, state_d;

  // Named events, brought out for the checks
  logic go_sleep, go_idle, leave_idle, leave_sleep;
  assign go_sleep    = (state_q == ST_RUN)   && sleep_req_i;
  assign go_idle     = (state_q == ST_RUN)   && !sleep_req_i && idle_req_i;
  assign leave_idle  = (state_q == ST_IDLE)  && irq_i;
  assign leave_sleep = (state_q == ST_SLEEP) && wake_i;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_RUN: begin
        if (go_sleep) begin
          state_d = ST_ENT_SLEEP; load_o = 1'b1; load_val_o = LD_R2S;
        end else if (go_idle) begin
          state_d = ST_ENT_IDLE;  load_o = 1'b1; load_val_o = LD_R2I;
        end
      end
      ST_IDLE: if (leave_idle) begin
        state_d = ST_EXIT_IDLE; load_o = 1'b1; load_val_o = LD_I2R;
      end
      ST_SLEEP: if (leave_sleep) begin
        state_d = ST_EXIT_SLEEP; load_o = 1'b1; load_val_o = LD_S2R;
      end
      ST_ENT_IDLE:   if (expired_i) state_d = ST_IDLE;
      ST_ENT_SLEEP:  if (expired_i) state_d = ST_SLEEP;
      ST_EXIT_IDLE:  if (expired_i) state_d = ST_RUN;
      ST_EXIT_SLEEP: if (expired_i) state_d = ST_RUN;
      default:       state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R7
  transit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_transient(state_q) && !expired_i) |=> $stable(state_q));

  // R8
  no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> (state_q != ST_ENT_SLEEP && state_q != ST_SLEEP));

  // R5
  idle_exit_only_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !irq_i) |=> (state_q == ST_IDLE));

  // R6
  sleep_exit_only_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && !wake_i) |=> (state_q == ST_SLEEP));

  // R4
  sleep_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_req_i && idle_req_i) |=> (state_q == ST_ENT_SLEEP));

endmodule

// File: rtl/pmc_gate_decode.sv
module pmc_gate_decode
  import pmc_pkg::*;
(
  input  pmc_state_e state_i,
  output logic       clk_gate_en_o,
  output logic       blk_shdn_en_o,
  output mode_e      mode_o,
  output logic       busy_o
);
  always_comb begin
    clk_gate_en_o = 1'b0;
    blk_shdn_en_o = 1'b0;
    mode_o        = MODE_RUN;
    unique case (state_i)
      ST_IDLE: begin
        clk_gate_en_o = 1'b1;
        mode_o        = MODE_IDLE;
      end
      ST_SLEEP: begin
        clk_gate_en_o = 1'b1;
        blk_shdn_en_o = 1'b1;
        mode_o        = MODE_SLEEP;
      end
      default: ;
    endcase
  end

  assign busy_o = is_transient(state_i);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned LAT_R2I_NS    = 10_000,
  parameter int unsigned LAT_I2R_NS    = 10_000,
  parameter int unsigned LAT_R2S_NS    = 90_000,
  parameter int unsigned LAT_S2R_NS    = 160_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_req_i,
  input  logic       sleep_req_i,
  input  logic       irq_i,
  input  logic       wake_i,
  output logic       clk_gate_en_o,
  output logic       blk_shdn_en_o,
  output logic [1:0] mode_o,
  output logic       busy_o
);
  localparam int unsigned CYC_R2I = lat_cycles(LAT_R2I_NS, CLK_PERIOD_PS);
  localparam int unsigned CYC_I2R = lat_cycles(LAT_I2R_NS, CLK_PERIOD_PS);
  localparam int unsigned CYC_R2S = lat_cycles(LAT_R2S_NS, CLK_PERIOD_PS);
  localparam int unsigned CYC_S2R = lat_cycles(LAT_S2R_NS, CLK_PERIOD_PS);
  localparam int unsigned CYC_MAX = max4(CYC_R2I, CYC_I2R, CYC_R2S, CYC_S2R);
  localparam int unsigned CNT_W   = (CYC_MAX < 2) ? 1 : $clog2(CYC_MAX);

  pmc_state_e       state;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_active;
  logic             tmr_expired;
  mode_e            mode_enum;

  pmc_mode_fsm #(
    .CNT_W   (CNT_W),
    .CYC_R2I (CYC_R2I),
    .CYC_I2R (CYC_I2R),
    .CYC_R2S (CYC_R2S),
    .CYC_S2R (CYC_S2R)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_req_i  (idle_req_i),
    .sleep_req_i (sleep_req_i),
    .irq_i       (irq_i),
    .wake_i      (wake_i),
    .expired_i   (tmr_expired),
    .state_o     (state),
    .load_o      (tmr_load),
    .load_val_o  (tmr_val)
  );

  pmc_latency_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .active_o   (tmr_active),
    .expired_o  (tmr_expired)
  );

  pmc_gate_decode u_dec (
    .state_i       (state),
    .clk_gate_en_o (clk_gate_en_o),
    .blk_shdn_en_o (blk_shdn_en_o),
    .mode_o        (mode_enum),
    .busy_o        (busy_o)
  );

  assign mode_o = mode_enum;

  // R2
  shdn_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_shdn_en_o |-> clk_gate_en_o);

  // R2
  gated_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!clk_gate_en_o && !blk_shdn_en_o));

  // R7
  busy_tracks_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == tmr_active);

  // R5
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && irq_i) |=> (mode_o == 2'd0 && busy_o && !clk_gate_en_o));

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
  localparam int unsigned PER_PS = 4000;
  localparam int unsigned R2I_NS = 40;
  localparam int unsigned I2R_NS = 36;
  localparam int unsigned R2S_NS = 82;
  localparam int unsigned S2R_NS = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_req = 1'b0, sleep_req = 1'b0, irq = 1'b0, wake = 1'b0;
  logic gate, shdn, busy;
  logic [1:0] mode;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(
    .CLK_PERIOD_PS (PER_PS),
    .LAT_R2I_NS    (R2I_NS),
    .LAT_I2R_NS    (I2R_NS),
    .LAT_R2S_NS    (R2S_NS),
    .LAT_S2R_NS    (S2R_NS)
  ) u_pwr_mode_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .idle_req_i    (idle_req),
    .sleep_req_i   (sleep_req),
    .irq_i         (irq),
    .wake_i        (wake),
    .clk_gate_en_o (gate),
    .blk_shdn_en_o (shdn),
    .mode_o        (mode),
    .busy_o        (busy)
  );

  int tests = 0;
  int fails = 0;

  // R9: count cycles by stepping until the period sum covers the latency
  function automatic int cyc_of(int unsigned ns);
    int n = 0;
    longint unsigned acc = 0;
    while (acc < 64'(ns) * 1000) begin
      acc += PER_PS;
      n++;
    end
    if (n == 0) n = 1;
    return n;
  endfunction

  int n_r2i, n_i2r, n_r2s, n_s2r;

  typedef struct {
    logic [1:0] mode;
    logic       gate;
    logic       shdn;
    logic       busy;
    string      tag;
  } exp_t;
  exp_t q[$];

  // bench model state
  int m_mode = 0;
  int m_left = 0;
  int m_target = 0;

  task automatic cyc(input bit i_idle, input bit i_slp, input bit i_irq,
                     input bit i_wk, input string tag);
    exp_t e;
    @(negedge clk);
    idle_req = i_idle; sleep_req = i_slp; irq = i_irq; wake = i_wk;
    if (m_left > 0) begin
      m_left--;
      if (m_left == 0) m_mode = m_target;
    end else if (m_mode == 0) begin
      if (i_slp)       begin m_left = n_r2s; m_target = 2; end
      else if (i_idle) begin m_left = n_r2i; m_target = 1; end
    end else if (m_mode == 1 && i_irq) begin
      m_mode = 0; m_target = 0; m_left = n_i2r;
    end else if (m_mode == 2 && i_wk) begin
      m_mode = 0; m_target = 0; m_left = n_s2r;
    end
    e.mode = 2'(m_mode);
    e.gate = (m_mode != 0);
    e.shdn = (m_mode == 2);
    e.busy = (m_left > 0);
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, tag);
  endtask

  // monitor: compare after each edge
  int busy_run = 0;
  int last_busy_len = 0;
  always @(posedge clk) begin
    #1;
    if (busy) busy_run++;
    else if (busy_run != 0) begin last_busy_len = busy_run; busy_run = 0; end
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      if (mode !== e.mode || gate !== e.gate || shdn !== e.shdn || busy !== e.busy) begin
        fails++;
        $display("FAIL %s: mode/gate/shdn/busy got %0d/%0b/%0b/%0b exp %0d/%0b/%0b/%0b",
                 e.tag, mode, gate, shdn, busy, e.mode, e.gate, e.shdn, e.busy);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    n_r2i = cyc_of(R2I_NS);
    n_i2r = cyc_of(I2R_NS);
    n_r2s = cyc_of(R2S_NS);
    n_s2r = cyc_of(S2R_NS);
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(mode === 2'd0 && !gate && !shdn && !busy, "R1", {mode, gate, shdn, busy}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(mode === 2'd0 && !gate && !shdn && !busy, "R1", {mode, gate, shdn, busy}, 0);

    quiet(3, "R2");
    // R3: enter Idle, R7: requests during the entry
    cyc(1, 0, 0, 0, "R3");
    cyc(0, 0, 1, 0, "R7");
    cyc(0, 1, 0, 1, "R7");
    quiet(n_r2i + 2, "R3");
    // R5 wake ignored in Idle, R8 sleep request ignored in Idle
    cyc(0, 0, 0, 1, "R5");
    cyc(0, 1, 0, 0, "R8");
    cyc(1, 1, 0, 1, "R8");
    quiet(2, "R2");
    // R5: interrupt exits Idle, R7 requests during exit
    cyc(0, 0, 1, 0, "R5");
    cyc(1, 1, 0, 0, "R7");
    cyc(0, 0, 1, 1, "R7");
    quiet(n_i2r + 2, "R5");
    // R4: sleep wins over idle; R7 exit events during entry
    cyc(1, 1, 0, 0, "R4");
    cyc(0, 0, 1, 1, "R7");
    cyc(0, 0, 0, 1, "R7");
    quiet(n_r2s + 2, "R4");
    // R6: interrupt ignored in Sleep, R8 idle request ignored
    cyc(0, 0, 1, 0, "R6");
    cyc(1, 0, 0, 0, "R8");
    cyc(1, 1, 1, 0, "R6");
    quiet(2, "R2");
    // R6: wake exits Sleep
    cyc(0, 0, 0, 1, "R6");
    cyc(0, 1, 0, 1, "R7");
    quiet(n_s2r + 2, "R6");
    @(posedge clk); #2;
    // R9: measured busy length of the Sleep exit
    check(last_busy_len == n_s2r, "R9", last_busy_len, n_s2r);
    // R9: Run-to-Sleep with rounding (82 ns at 4 ns period)
    cyc(0, 1, 0, 0, "R9");
    quiet(n_r2s + 2, "R9");
    @(posedge clk); #2;
    check(last_busy_len == n_r2s && n_r2s == 21, "R9", last_busy_len, 21);
    cyc(0, 0, 0, 1, "R6");
    quiet(n_s2r + 2, "R6");
    // back-to-back: idle request held high through entry and Idle
    cyc(1, 0, 0, 0, "R3");
    for (int i = 0; i < n_r2i + 2; i++) cyc(1, 0, 0, 0, "R3");
    cyc(1, 0, 1, 0, "R5");
    quiet(n_i2r + 2, "R5");
    repeat (3) @(posedge clk);
    #2;
    check(q.size() == 0, "R2", q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule